// File: doc/BRIEF.md
# DMA Transfer Sequencer (Element/Frame Counter)

This block is the counting and address-sequencing core of one active DMA channel. A control packet (source and destination base addresses, element count, frame count, per-side element and frame offsets, per-side access sizes, per-side address modes, a transfer type and an auto-reinitialise flag) is latched on a start pulse. The block then waits for triggers and presents one element at a time as a read address and a write address, each with its own access size. The bus side is reduced to a single `ready_i` that accepts the element being presented.

A block is the frame count multiplied by the element count. In element mode each trigger moves one element. In frame mode each trigger moves every element of the current frame. Single-cycle flags report the end of a frame, the half-way point of the block and the end of the block. With auto-reinitialise set, the channel reloads its addresses and counts from the latched packet after the last element and stays armed. This gives continuous ring or ping-pong operation, where software refills one half while the other half drains.

Top module: `dma_xfer_seq`

## Requirements
- R1: A start with an element count or frame count of zero leaves the channel idle (`busy_o` low): no element is presented and no flag is raised until the next start.
- R2: With transfer type 0 (element), each trigger accepted while armed presents exactly one element. After that element is accepted, `xfer_o` drops and the channel waits for the next trigger.
- R3: With transfer type 1 (frame), one trigger presents all elements of the current frame back to back (subject to `ready_i`). The channel then waits for the next trigger.
- R4: Address mode 0 (fixed; code 3 behaves the same) keeps that side's address at its base for every element.
- R5: In address mode 1 (increment), the address advances after each element by the access size of that side: 2 bytes for size code 0 (16-bit) and 4 bytes for size code 1 (32-bit). Read and write sizes are independent and are shown on `rd_size_o` and `wr_size_o`.
- R6: In address mode 2 (offset), the signed 16-bit element offset is added after each element. On the last element of a frame the signed frame offset is added instead. Source and destination use their own offsets.
- R7: `frame_done_o` pulses for one cycle, in the cycle after the last element of each frame is accepted.
- R8: `block_done_o` pulses for one cycle, together with `frame_done_o`, after the last element of the last frame is accepted.
- R9: When the block holds at least two elements, `half_done_o` pulses for one cycle after the number of accepted elements reaches floor(block/2). It pulses once per pass.
- R10: After block completion, auto-reinitialise on reloads the base addresses and counts and keeps the channel armed. With auto-reinitialise off, the channel goes idle.
- R11: While `ready_i` is low, the presented element and both addresses are held unchanged.
- R12: A trigger is ignored while idle or while elements are being presented. A start pulse at any time abandons the current pass and loads the new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Latch the packet and arm the channel |
| trig_i | input | 1 | Transfer request |
| ready_i | input | 1 | Bus accepts the presented element |
| src_addr_i | input | ADDR_W | Source base address |
| dst_addr_i | input | ADDR_W | Destination base address |
| elem_cnt_i | input | CNT_W | Elements per frame |
| frame_cnt_i | input | CNT_W | Frames per block |
| src_eoff_i | input | OFF_W | Signed source element offset |
| dst_eoff_i | input | OFF_W | Signed destination element offset |
| src_foff_i | input | OFF_W | Signed source frame offset |
| dst_foff_i | input | OFF_W | Signed destination frame offset |
| rd_size_i | input | 1 | Read size (0 = 16-bit, 1 = 32-bit) |
| wr_size_i | input | 1 | Write size (0 = 16-bit, 1 = 32-bit) |
| rd_mode_i | input | 2 | Read address mode (0 fixed, 1 increment, 2 offset) |
| wr_mode_i | input | 2 | Write address mode (0 fixed, 1 increment, 2 offset) |
| xfer_type_i | input | 1 | 0 = element per trigger, 1 = frame per trigger |
| auto_init_i | input | 1 | Reload and rearm after block completion |
| busy_o | output | 1 | Channel armed |
| xfer_o | output | 1 | Element presented this cycle |
| rd_addr_o | output | ADDR_W | Read address of presented element |
| wr_addr_o | output | ADDR_W | Write address of presented element |
| rd_size_o | output | 1 | Latched read size |
| wr_size_o | output | 1 | Latched write size |
| frame_done_o | output | 1 | Frame complete pulse |
| half_done_o | output | 1 | Half block pulse |
| block_done_o | output | 1 | Block complete pulse |

## Verification
The assertions assume that packet fields are read only in the cycle of `start_i` and that `ready_i` means nothing while `xfer_o` is low. The stimulus holds the packet inputs steady around each start and toggles `ready_i` freely. It also assumes that a start may arrive in any state, so the stimulus occasionally restarts in mid-pass. Counts are kept small (zero to five), so that many whole blocks, auto-reinitialise wraps and frame boundaries occur. Offsets and bases span the full signed and unsigned ranges, so that address wrap-around is reached.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    AM_FIXED = 2'd0,
    AM_INCR  = 2'd1,
    AM_OFFS  = 2'd2,
    AM_RSVD  = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_MOVE = 2'd2
  } seq_state_e;

  localparam logic XT_ELEM  = 1'b0;
  localparam logic XT_FRAME = 1'b1;
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic                step_i,
  input  logic                frame_end_i,
  input  logic [1:0]          mode_i,
  input  logic                size_i,
  input  logic [OFF_W-1:0]    eoff_i,
  input  logic [OFF_W-1:0]    foff_i,
  output logic [ADDR_W-1:0]   addr_o
);
  import dma_seq_pkg::*;

  localparam int PAD_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] addr_q, inc_w, eoff_x, foff_x;
  addr_mode_e mode;

  assign mode   = addr_mode_e'(mode_i);
  assign eoff_x = {{PAD_W{eoff_i[OFF_W-1]}}, eoff_i};
  assign foff_x = {{PAD_W{foff_i[OFF_W-1]}}, foff_i};

  always_comb begin
    unique case (mode)
      AM_INCR: inc_w = size_i ? ADDR_W'(4) : ADDR_W'(2);
      AM_OFFS: inc_w = frame_end_i ? foff_x : eoff_x;
      default: inc_w = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= base_i;
    else if (step_i) addr_q <= addr_q + inc_w;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dma_cnt_unit.sv
module dma_cnt_unit #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] elem_cnt_i,
  input  logic [CNT_W-1:0] frame_cnt_i,
  output logic             last_elem_o,
  output logic             last_blk_o,
  output logic             half_hit_o
);
  localparam int TOT_W = 2 * CNT_W;

  logic [CNT_W-1:0] e_q, f_q;
  logic [TOT_W-1:0] moved_q, total_w, half_w;

  assign total_w     = TOT_W'(elem_cnt_i) * TOT_W'(frame_cnt_i);
  assign half_w      = total_w >> 1;
  assign last_elem_o = (e_q == elem_cnt_i - CNT_W'(1));
  assign last_blk_o  = last_elem_o && (f_q == frame_cnt_i - CNT_W'(1));
  assign half_hit_o  = (total_w >= TOT_W'(2)) && (moved_q + TOT_W'(1) == half_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_q <= '0; f_q <= '0; moved_q <= '0;
    end else if (load_i || (step_i && last_blk_o)) begin
      e_q <= '0; f_q <= '0; moved_q <= '0;
    end else if (step_i) begin
      moved_q <= moved_q + TOT_W'(1);
      if (last_elem_o) begin
        e_q <= '0;
        f_q <= f_q + CNT_W'(1);
      end else begin
        e_q <= e_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8,
  parameter int OFF_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              trig_i,
  input  logic              ready_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [CNT_W-1:0]  elem_cnt_i,
  input  logic [CNT_W-1:0]  frame_cnt_i,
  input  logic [OFF_W-1:0]  src_eoff_i,
  input  logic [OFF_W-1:0]  dst_eoff_i,
  input  logic [OFF_W-1:0]  src_foff_i,
  input  logic [OFF_W-1:0]  dst_foff_i,
  input  logic              rd_size_i,
  input  logic              wr_size_i,
  input  logic [1:0]        rd_mode_i,
  input  logic [1:0]        wr_mode_i,
  input  logic              xfer_type_i,
  input  logic              auto_init_i,
  output logic              busy_o,
  output logic              xfer_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              rd_size_o,
  output logic              wr_size_o,
  output logic              frame_done_o,
  output logic              half_done_o,
  output logic              block_done_o
);
  import dma_seq_pkg::*;

  localparam int NSIDE = 2;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [OFF_W-1:0]  eoff;
    logic [OFF_W-1:0]  foff;
    logic [1:0]        mode;
    logic              size;
  } side_cfg_t;

  typedef struct packed {
    side_cfg_t        rd;
    side_cfg_t        wr;
    logic [CNT_W-1:0] ecnt;
    logic [CNT_W-1:0] fcnt;
    logic             xtype;
    logic             autoi;
  } pkt_t;

  pkt_t       pkt_q, pkt_in;
  seq_state_e st_q, st_d;
  logic       step, last_elem, last_blk, half_hit, zero_cnt, reload, addr_load;
  logic       fd_q, hd_q, bd_q;

  assign pkt_in = '{
    rd:    '{base: src_addr_i, eoff: src_eoff_i, foff: src_foff_i, mode: rd_mode_i, size: rd_size_i},
    wr:    '{base: dst_addr_i, eoff: dst_eoff_i, foff: dst_foff_i, mode: wr_mode_i, size: wr_size_i},
    ecnt:  elem_cnt_i,
    fcnt:  frame_cnt_i,
    xtype: xfer_type_i,
    autoi: auto_init_i
  };

  assign zero_cnt  = (elem_cnt_i == '0) || (frame_cnt_i == '0);
  assign step      = (st_q == ST_MOVE) && ready_i && !start_i;
  assign reload    = step && last_blk && pkt_q.autoi;
  assign addr_load = start_i || reload;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pkt_q <= '0;
    else if (start_i) pkt_q <= pkt_in;
  end

  always_comb begin
    st_d = st_q;
    if (start_i) begin
      st_d = zero_cnt ? ST_IDLE : ST_WAIT;
    end else begin
      unique case (st_q)
        ST_WAIT: if (trig_i) st_d = ST_MOVE;
        ST_MOVE: if (ready_i) begin
          if (last_blk)                     st_d = pkt_q.autoi ? ST_WAIT : ST_IDLE;
          else if (pkt_q.xtype == XT_ELEM)  st_d = ST_WAIT;
          else if (last_elem)               st_d = ST_WAIT;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      fd_q <= 1'b0; hd_q <= 1'b0; bd_q <= 1'b0;
    end else begin
      st_q <= st_d;
      fd_q <= step && last_elem;
      hd_q <= step && half_hit;
      bd_q <= step && last_blk;
    end
  end

  dma_cnt_unit #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start_i),
    .step_i      (step),
    .elem_cnt_i  (pkt_q.ecnt),
    .frame_cnt_i (pkt_q.fcnt),
    .last_elem_o (last_elem),
    .last_blk_o  (last_blk),
    .half_hit_o  (half_hit)
  );

  side_cfg_t         cfg_q  [NSIDE];
  side_cfg_t         cfg_in [NSIDE];
  logic [ADDR_W-1:0] addr   [NSIDE];

  assign cfg_q[0]  = pkt_q.rd;
  assign cfg_q[1]  = pkt_q.wr;
  assign cfg_in[0] = pkt_in.rd;
  assign cfg_in[1] = pkt_in.wr;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dma_addr_unit #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (addr_load),
      .base_i      (start_i ? cfg_in[s].base : cfg_q[s].base),
      .step_i      (step),
      .frame_end_i (last_elem),
      .mode_i      (cfg_q[s].mode),
      .size_i      (cfg_q[s].size),
      .eoff_i      (cfg_q[s].eoff),
      .foff_i      (cfg_q[s].foff),
      .addr_o      (addr[s])
    );
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign xfer_o       = (st_q == ST_MOVE);
  assign rd_addr_o    = addr[0];
  assign wr_addr_o    = addr[1];
  assign rd_size_o    = pkt_q.rd.size;
  assign wr_size_o    = pkt_q.wr.size;
  assign frame_done_o = fd_q;
  assign half_done_o  = hd_q;
  assign block_done_o = bd_q;
endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              ready_i,
  input logic [CNT_W-1:0]  elem_cnt_i,
  input logic [CNT_W-1:0]  frame_cnt_i,
  input logic              busy_o,
  input logic              xfer_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_size_o,
  input logic              frame_done_o,
  input logic              half_done_o,
  input logic              block_done_o,
  input logic [1:0]        rd_mode,
  input logic              xtype,
  input logic              blk_last
);
  logic beat;
  assign beat = xfer_o && ready_i && !start_i;

  AST_ZERO_NO_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (elem_cnt_i == '0 || frame_cnt_i == '0) |=> !busy_o); // R1

  AST_ELEM_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat && xtype == 1'b0 |=> !xfer_o); // R2

  AST_FIXED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat && rd_mode == 2'd0 |=> $stable(rd_addr_o)); // R4

  AST_INCR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat && rd_mode == 2'd1 && !blk_last
    |=> rd_addr_o == $past(rd_addr_o) + (rd_size_o ? ADDR_W'(4) : ADDR_W'(2))); // R5

  AST_FLAG_NEEDS_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o || half_done_o |-> $past(xfer_o && ready_i)); // R7

  AST_BLOCK_WITH_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_done_o |-> frame_done_o); // R8

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o && !ready_i && !start_i |=> xfer_o && $stable(rd_addr_o)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !xfer_o); // R12
endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .ready_i      (ready_i),
  .elem_cnt_i   (elem_cnt_i),
  .frame_cnt_i  (frame_cnt_i),
  .busy_o       (busy_o),
  .xfer_o       (xfer_o),
  .rd_addr_o    (rd_addr_o),
  .rd_size_o    (rd_size_o),
  .frame_done_o (frame_done_o),
  .half_done_o  (half_done_o),
  .block_done_o (block_done_o),
  .rd_mode      (pkt_q.rd.mode),
  .xtype        (pkt_q.xtype),
  .blk_last     (last_blk)
);

// File: tb/dma_xfer_seq_bench.sv
module dma_xfer_seq_bench;
  localparam int AW = 32, CW = 8, OW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, trig = 0, ready = 0;
  logic [AW-1:0] src = '0, dst = '0;
  logic [CW-1:0] ecnt = '0, fcnt = '0;
  logic [OW-1:0] seo = '0, deo = '0, sfo = '0, dfo = '0;
  logic rsz = 0, wsz = 0, xtyp = 0, autoi = 0;
  logic [1:0] rmode = '0, wmode = '0;

  logic busy, xfer, rsz_o, wsz_o, fd, hd, bd;
  logic [AW-1:0] raddr, waddr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_xfer_seq #(.ADDR_W(AW), .CNT_W(CW), .OFF_W(OW)) u_dma_xfer_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .trig_i(trig), .ready_i(ready),
    .src_addr_i(src), .dst_addr_i(dst), .elem_cnt_i(ecnt), .frame_cnt_i(fcnt),
    .src_eoff_i(seo), .dst_eoff_i(deo), .src_foff_i(sfo), .dst_foff_i(dfo),
    .rd_size_i(rsz), .wr_size_i(wsz), .rd_mode_i(rmode), .wr_mode_i(wmode),
    .xfer_type_i(xtyp), .auto_init_i(autoi),
    .busy_o(busy), .xfer_o(xfer), .rd_addr_o(raddr), .wr_addr_o(waddr),
    .rd_size_o(rsz_o), .wr_size_o(wsz_o),
    .frame_done_o(fd), .half_done_o(hd), .block_done_o(bd)
  );

  // reference model state: 0 idle, 1 armed, 2 moving
  int m_st = 0, m_n = 0, m_e = 0, m_f = 0;
  logic m_fd = 0, m_hd = 0, m_bd = 0;
  logic [AW-1:0] m_src, m_dst;
  logic [OW-1:0] m_seo, m_deo, m_sfo, m_dfo;
  logic [1:0] m_rm, m_wm;
  logic m_rsz, m_wsz, m_xt, m_ai;

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] base, logic [1:0] mode, logic sz,
                                             logic [OW-1:0] eo, logic [OW-1:0] fo, int e, int n);
    logic [AW-1:0] eox = {{(AW-OW){eo[OW-1]}}, eo};
    logic [AW-1:0] fox = {{(AW-OW){fo[OW-1]}}, fo};
    logic [AW-1:0] fr = AW'(n / e);
    logic [AW-1:0] el = AW'(n % e);
    case (mode)
      2'd1:    return base + AW'(n) * (sz ? AW'(4) : AW'(2));
      2'd2:    return base + fr * (AW'(e - 1) * eox + fox) + el * eox;
      default: return base;
    endcase
  endfunction

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string addr_req(logic [1:0] m);
    return (m == 2'd1) ? "R5 incr addr" : (m == 2'd2) ? "R6 offset addr" : "R4 fixed addr";
  endfunction

  // inputs are set at a falling edge; the model mirrors the coming rising edge
  task automatic cyc(logic s, logic t, logic r);
    start = s; trig = t; ready = r;
    m_fd = 0; m_hd = 0; m_bd = 0;
    if (s) begin
      m_src = src; m_dst = dst; m_seo = seo; m_deo = deo; m_sfo = sfo; m_dfo = dfo;
      m_rm = rmode; m_wm = wmode; m_rsz = rsz; m_wsz = wsz; m_xt = xtyp; m_ai = autoi;
      m_e = int'(ecnt); m_f = int'(fcnt); m_n = 0;
      m_st = (m_e == 0 || m_f == 0) ? 0 : 1;
    end else if (m_st == 1) begin
      if (t) m_st = 2;                       // R12: trigger only counts when armed
    end else if (m_st == 2 && r) begin
      m_n++;
      m_fd = (m_n % m_e == 0);
      m_bd = (m_n == m_e * m_f);
      m_hd = (m_e * m_f >= 2) && (m_n == (m_e * m_f) / 2);
      if (m_bd) begin
        m_n = 0;
        m_st = m_ai ? 1 : 0;                 // R10
      end else if (!m_xt || m_fd) m_st = 1;  // R2, R3
    end
    @(negedge clk);
    chk("R1/R10 busy", AW'(busy), AW'(m_st != 0));
    chk("R2/R3 xfer", AW'(xfer), AW'(m_st == 2));
    chk("R7 frame_done", AW'(fd), AW'(m_fd));
    chk("R8 block_done", AW'(bd), AW'(m_bd));
    chk("R9 half_done", AW'(hd), AW'(m_hd));
    if (m_st == 2) begin
      chk(addr_req(m_rm), raddr, exp_addr(m_src, m_rm, m_rsz, m_seo, m_sfo, m_e, m_n));
      chk(addr_req(m_wm), waddr, exp_addr(m_dst, m_wm, m_wsz, m_deo, m_dfo, m_e, m_n));
      chk("R5 sizes", AW'({rsz_o, wsz_o}), AW'({m_rsz, m_wsz}));
    end
  endtask

  task automatic rand_pkt(bit allow_zero);
    src = $urandom; dst = $urandom;
    ecnt = CW'(allow_zero ? $urandom_range(0, 5) : $urandom_range(1, 5));
    fcnt = CW'(allow_zero ? $urandom_range(0, 4) : $urandom_range(1, 4));
    seo = OW'($urandom); deo = OW'($urandom); sfo = OW'($urandom); dfo = OW'($urandom);
    rsz = $urandom_range(0, 1); wsz = $urandom_range(0, 1);
    rmode = 2'($urandom_range(0, 3)); wmode = 2'($urandom_range(0, 3));
    xtyp = $urandom_range(0, 1); autoi = $urandom_range(0, 1);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset busy", AW'(busy), '0);
    chk("reset flags", AW'({xfer, fd, hd, bd}), '0);

    // R1: zero element count, then triggers: nothing happens
    rand_pkt(0); ecnt = '0;
    cyc(1, 0, 1);
    for (int i = 0; i < 6; i++) cyc(0, 1, 1);

    // R3, R6, R11: frame mode, offset addressing, stalls mid-frame
    rand_pkt(0); ecnt = 3; fcnt = 2; xtyp = 1; autoi = 0; rmode = 2; wmode = 2;
    cyc(1, 0, 0);
    cyc(0, 1, 0);
    for (int i = 0; i < 16; i++) cyc(0, i % 5 == 0, i % 3 != 0);

    // R10, R9: auto-reinitialise ring, element mode, increment, trigger while moving (R12)
    rand_pkt(0); ecnt = 2; fcnt = 2; xtyp = 0; autoi = 1; rmode = 1; wmode = 0;
    cyc(1, 0, 1);
    for (int i = 0; i < 30; i++) cyc(0, 1, 1);

    // R12: restart in mid-pass
    rand_pkt(0); ecnt = 4; fcnt = 3; xtyp = 1;
    cyc(1, 0, 1);
    cyc(0, 1, 1);
    cyc(0, 0, 1);
    rand_pkt(0);
    cyc(1, 1, 1);
    for (int i = 0; i < 20; i++) cyc(0, 1, 1);

    // constrained random passes
    for (int p = 0; p < 80; p++) begin
      rand_pkt(1);
      cyc(1, 0, $urandom_range(0, 1));
      for (int c = 0; c < 120; c++) begin
        logic s = ($urandom_range(0, 199) == 0);
        if (s) rand_pkt(1);
        cyc(s, $urandom_range(0, 3) == 0, $urandom_range(0, 3) != 0);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule